// File: doc/BRIEF.md
# Two-Port GPIO Expander Register and Interrupt Core

This block holds the register file and pin logic of a 16-line general-purpose I/O expander that is split into two 8-bit ports. A host reaches it through a simple register interface. A write strobe or a read strobe comes with a register index and a data byte. That interface takes the place of a serial-bus slave, which is kept outside the block. For each port the block keeps four registers: a captured input value, a latched output value, a per-bit inversion mask for input readback, and a per-bit direction setting.

Each pin drives the tri-state pad from its latched output only while its direction bit selects output. Every pin is resynchronised through two flops before any other logic uses it. The block asks for an interrupt when an input-configured pin's synchronised level no longer matches the value last captured for it. The interrupt is an enable that pulls an external open-drain line low. Reading a port's input register captures the pins again, and that clears the port's part of the interrupt.

Top module: `gpx_core`

## Requirements
- R1: When reset ends, every direction bit is 1 (input), so pin_oe is all zero. The output registers are 8'hFF, so pin_out is all ones. The inversion registers are 8'h00. Reading index 2..7 returns FF, FF, 00, 00, FF, FF.
- R2: A write to index 2/3 (output, port 0/1), 4/5 (inversion) or 6/7 (direction) updates that register at the write's clock edge. A read of the same index then returns the written byte. Index = kind*2 + port, with the kinds input=0, output=1, inversion=2, direction=3.
- R3: A pin_oe bit is 1 exactly when its direction bit is 0. pin_out carries the output registers, with port 0 on bits 7:0 and port 1 on bits 15:8.
- R4: A read of index 0/1 returns rd_data one cycle after rd_en. The value is the port's two-flop synchronised pin levels XOR its inversion register. A pin change reaches the synchroniser output two clock edges after it is applied.
- R5: A write to index 0 or 1 changes no register. A later read of the same input index still returns the same value, and the direction registers keep their values.
- R6: int_pull is 1 while any pin whose direction bit is 1 has a synchronised level that differs from its captured input bit. Pins configured as outputs are ignored in this comparison.
- R7: A read of a port's input register stores the synchronised pins in that register. This clears that port's mismatch while the pins are steady, and leaves the other port's mismatch standing.
- R8: Holding rst_n low at a clock edge restores all the R1 defaults. It also clears both captured input registers and the synchroniser to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_idx | input | 3 | Register index (kind*NUM_PORTS + port) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, registered, valid the cycle after rd_en |
| pin_in | input | 16 | Pad input levels |
| pin_out | output | 16 | Pad output levels |
| pin_oe | output | 16 | Pad output enables (1 = drive) |
| int_pull | output | 1 | 1 = pull the open-drain interrupt line low |

## Verification
The bench builds the block with its defaults, two ports of eight bits. This gives an eight-entry index space in which every input, output, inversion and direction register of both ports can be addressed. With two ports, the bench can set up a mismatch on each port, clear one of them by reading its input register, and see the other still hold int_pull. With distinct values in the two inversion masks, a swapped port or a missing XOR shows up in the readback.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        KIND_IN  = 2'd0,
        KIND_OUT = 2'd1,
        KIND_POL = 2'd2,
        KIND_CFG = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic [DATA_W-1:0] outr;
        logic [DATA_W-1:0] pol;
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] inr;
    } port_regs_t;

    localparam port_regs_t PORT_RST = '{outr: 8'hFF, pol: 8'h00, cfg: 8'hFF, inr: 8'h00};

    function automatic logic [DATA_W-1:0] input_view(logic [DATA_W-1:0] lvl, logic [DATA_W-1:0] inv);
        return lvl ^ inv;
    endfunction
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= d;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpx_port.sv
module gpx_port
    import gpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_out,
    input  logic              wr_pol,
    input  logic              wr_cfg,
    input  logic              cap,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] pins_s,
    output port_regs_t        regs,
    output logic [DATA_W-1:0] mism
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= PORT_RST;
        end else begin
            if (wr_out) regs.outr <= wr_data;
            if (wr_pol) regs.pol  <= wr_data;
            if (wr_cfg) regs.cfg  <= wr_data;
            if (cap)    regs.inr  <= pins_s;
        end
    end

    assign mism = (pins_s ^ regs.inr) & regs.cfg;

    // direction write lands in the register that enables the pads
    assert_cfg_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && rst_n) |=> (regs.cfg == $past(wr_data)));

    // input register moves only on a capture
    assert_input_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !cap) |=> $stable(regs.inr));

    // capture with steady pins leaves no mismatch
    assert_capture_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && rst_n) |=> (!$stable(pins_s) || (mism == '0)));
endmodule

// File: rtl/gpx_core.sv
module gpx_core
    import gpx_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int IDX_W     = $clog2(4 * NUM_PORTS),
    parameter int NBITS     = NUM_PORTS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NBITS-1:0]  pin_in,
    output logic [NBITS-1:0]  pin_out,
    output logic [NBITS-1:0]  pin_oe,
    output logic              int_pull
);
    logic [NBITS-1:0]  pins_s;
    port_regs_t        regs_a [NUM_PORTS];
    logic [NBITS-1:0]  mism_v;
    int                idx_i, kind_i, port_sel;
    logic              kind_ok;
    reg_kind_e         kind_e;
    logic [DATA_W-1:0] rd_value;

    gpx_sync #(.W(NBITS), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_s)
    );

    always_comb begin
        idx_i    = int'(reg_idx);
        kind_i   = idx_i / NUM_PORTS;
        port_sel = idx_i % NUM_PORTS;
        kind_ok  = (kind_i < 4);
        kind_e   = reg_kind_e'(kind_i[1:0]);
    end

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            logic hit;
            assign hit = kind_ok && (port_sel == p);

            gpx_port u_port (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_out (wr_en && hit && kind_e == KIND_OUT),
                .wr_pol (wr_en && hit && kind_e == KIND_POL),
                .wr_cfg (wr_en && hit && kind_e == KIND_CFG),
                .cap    (rd_en && hit && kind_e == KIND_IN),
                .wr_data(wr_data),
                .pins_s (pins_s[p*DATA_W +: DATA_W]),
                .regs   (regs_a[p]),
                .mism   (mism_v[p*DATA_W +: DATA_W])
            );

            assign pin_out[p*DATA_W +: DATA_W] = regs_a[p].outr;
            assign pin_oe[p*DATA_W +: DATA_W]  = ~regs_a[p].cfg;
        end
    endgenerate

    always_comb begin
        rd_value = '0;
        if (kind_ok) begin
            case (kind_e)
                KIND_IN:  rd_value = input_view(pins_s[port_sel*DATA_W +: DATA_W], regs_a[port_sel].pol);
                KIND_OUT: rd_value = regs_a[port_sel].outr;
                KIND_POL: rd_value = regs_a[port_sel].pol;
                KIND_CFG: rd_value = regs_a[port_sel].cfg;
                default:  rd_value = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_value;
    end

    assign int_pull = |mism_v;

    // reset restores pad defaults
    assert_reset_pads_R8: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '1));

    // an interrupt can only be requested by an input-configured pin
    assert_int_needs_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int_pull |-> (pin_oe != '1));
endmodule

// File: tb/test_gpx_core.sv
module test_gpx_core;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0, rd_en = 0;
    logic [2:0]  reg_idx = 0;
    logic [7:0]  wr_data = 0;
    logic [7:0]  rd_data;
    logic [15:0] pin_in = 0;
    logic [15:0] pin_out, pin_oe;
    logic        int_pull;
    int          checks = 0, failures = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    gpx_core i_gpx_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_idx(reg_idx),
        .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .int_pull(int_pull)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [2:0] idx, logic [7:0] d);
        @(negedge clk); wr_en = 1; reg_idx = idx; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic do_read(logic [2:0] idx, output logic [7:0] d);
        @(negedge clk); rd_en = 1; reg_idx = idx;
        @(negedge clk); rd_en = 0; d = rd_data;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 oe", pin_oe, 16'h0000);
        check("R1 out", pin_out, 16'hFFFF);
        check("R1 int", {15'd0, int_pull}, 16'd0);
        do_read(2, d); check("R1 out0", {8'd0, d}, 16'h00FF);
        do_read(5, d); check("R1 pol1", {8'd0, d}, 16'h0000);
        do_read(7, d); check("R1 cfg1", {8'd0, d}, 16'h00FF);
    endtask

    task automatic t_writes;
        logic [7:0] d;
        do_write(2, 8'hA5); do_write(3, 8'h3C);
        do_write(4, 8'h0F); do_write(5, 8'hF0);
        do_write(6, 8'h55); do_write(7, 8'hAA);
        do_read(3, d); check("R2 out1", {8'd0, d}, 16'h003C);
        do_read(4, d); check("R2 pol0", {8'd0, d}, 16'h000F);
        do_read(6, d); check("R2 cfg0", {8'd0, d}, 16'h0055);
        check("R3 oe", pin_oe, 16'h55AA);
        check("R3 out", pin_out, 16'h3CA5);
        do_write(6, 8'hFF); do_write(7, 8'hFF);
        check("R3 oe off", pin_oe, 16'h0000);
    endtask

    task automatic t_inputs;
        logic [7:0] d;
        @(negedge clk); pin_in = 16'h1234;
        wait_cyc(3);
        do_read(0, d); check("R4 in0", {8'd0, d}, 16'h003B);
        do_read(1, d); check("R4 in1", {8'd0, d}, 16'h00E2);
        do_write(0, 8'hFF); do_write(1, 8'h00);
        do_read(0, d); check("R5 in0 kept", {8'd0, d}, 16'h003B);
        do_read(6, d); check("R5 cfg0 kept", {8'd0, d}, 16'h00FF);
        check("R6 quiet", {15'd0, int_pull}, 16'd0);
    endtask

    task automatic t_interrupt;
        logic [7:0] d;
        @(negedge clk); pin_in = 16'h1235;
        @(posedge clk); @(negedge clk);
        check("R4 latency", {15'd0, int_pull}, 16'd0);
        @(posedge clk); @(negedge clk);
        check("R6 raise", {15'd0, int_pull}, 16'd1);
        do_write(6, 8'hFE);
        check("R6 output ignored", {15'd0, int_pull}, 16'd0);
        do_write(6, 8'hFF);
        check("R6 reraise", {15'd0, int_pull}, 16'd1);
        @(negedge clk); pin_in = 16'h1335;
        wait_cyc(3);
        do_read(0, d); check("R7 in0", {8'd0, d}, 16'h003A);
        check("R7 port1 holds", {15'd0, int_pull}, 16'd1);
        do_read(1, d); check("R7 in1", {8'd0, d}, 16'h00E3);
        check("R7 cleared", {15'd0, int_pull}, 16'd0);
    endtask

    task automatic t_rereset;
        logic [7:0] d;
        do_write(7, 8'h0F);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        check("R8 oe", pin_oe, 16'h0000);
        check("R8 out", pin_out, 16'hFFFF);
        check("R8 int low", {15'd0, int_pull}, 16'd0);
        wait_cyc(2);
        check("R8 inr zero", {15'd0, int_pull}, 16'd1);
        do_read(4, d); check("R8 pol0", {8'd0, d}, 16'h0000);
        do_read(7, d); check("R8 cfg1", {8'd0, d}, 16'h00FF);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_writes;
        t_inputs;
        t_interrupt;
        t_rereset;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule